// File: doc/BRIEF.md
# Fractional Root Clock Generator

This block generates a root clock from one of several source clocks. Each source is presented as a one-cycle tick on the system clock, and each tick stands for one source period. The block chooses one source and passes it through an integer pre-divider. When fractional mode is enabled, an M/N accumulator then sets the output rate, and a threshold value sets the high time. The output is a pair of signals. The first is a pulse that marks the start of each output period. The second is a level that holds the output waveform and changes only on ticks of the selected source.

Software programs a set of shadow registers. Two of these registers use encoded forms. The N register holds the bit-inverse of (N − M). The threshold register holds the bit-inverse of the half-step high-time value. Writing the update bit in the command register requests a commit. The hardware decodes the shadow registers and loads them into the active configuration at the end of the current output period, and then clears the update bit. Because the switch happens only at a period boundary, a change of source or ratio never cuts an output pulse short.

Top module: `mnd_root_clkgen`

## Requirements
- R1: After reset, the bus reads 0 at every register, `gen_tick` and `gen_level` are 0, and the active setup is source 0, divide-by-1, integer path. In this state each source-0 tick produces `gen_tick`=1 and `gen_level`=1 in the following cycle.
- R2: The register map is: word 0 setup, word 1 command, word 2 M, word 3 inverted N−M, word 4 inverted threshold. In the setup word, bits [3:0] are the pre-divide value P, bits [9:8] the source, and bits [13:12] the mode (2 = fractional). The M, N and threshold words read back masked to 8 bits. Unmapped bits and unmapped words read 0.
- R3: Writes to the setup, M, N and threshold words do not change the outputs until a commit is applied.
- R4: Writing 1 to bit 0 of the command word sets a pending bit, which reads back at bit 0. The pending bit clears in the cycle that the commit is applied. A commit is applied only on a tick of the selected source that ends the current output period. If a write of 1 arrives in the same cycle as an apply, the write wins.
- R5: In integer mode, a period lasts P+1 selected ticks, numbered p = 0..P. On tick p, the block sets `gen_tick` = (p==0) and `gen_level` = (2p < P+1). The last tick of the period is p = P.
- R6: In fractional mode, the pre-divided tick (p == P) steps an accumulator A, starting at 0, to (A+M) mod N. On that tick, `gen_tick` = (A < M) and `gen_level` = (2A < H), both using the A value held before the step. The period ends on a step that wraps.
- R7: On commit, N is decoded as (~Nreg & 0xFF) + M and H as ~Dreg & 0xFF.
- R8: Fractional mode is used only when the mode is 2 and M ≠ 0. Otherwise the integer path is used.
- R9: Only ticks of the active source advance the block. A new source takes effect only after the old period completes.
- R10: `gen_tick` lasts one cycle, and `gen_level` holds in every cycle that has no selected tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| src_tick | input | NUM_SRC | One pulse per period of each source |
| gen_tick | output | 1 | Start-of-output-period pulse |
| gen_level | output | 1 | Output clock waveform level |

## Verification
The assertions take for granted that software never programs an N−M difference of zero. In other words, the inverted N field is never all ones, so M < N always holds and one subtraction is enough to keep the accumulator in range. They also assume that the active source keeps ticking, because a commit waits for that source to end a period. The random stimulus draws N−M from 1 to 8, M from 0 to 5 and the pre-divide value from 0 to 3. It raises each source tick with probability one half, so every commit is applied within a short window.

// File: rtl/mnd_rcg_pkg.sv
// Package: shared widths, register map and active-configuration type for the
// fractional root clock generator. Assumes a 32-bit register bus.
package mnd_rcg_pkg;
    parameter int DATA_W   = 32;
    parameter int ADDR_W   = 3;
    parameter int DIV_W    = 4;
    parameter int SRC_W    = 2;
    parameter int MODE_W   = 2;
    parameter int MND_W    = 8;

    parameter int DIV_LSB  = 0;
    parameter int SRC_LSB  = 8;
    parameter int MODE_LSB = 12;
    parameter int UPD_BIT  = 0;

    localparam logic [ADDR_W-1:0] A_SETUP = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 3'd1;
    localparam logic [ADDR_W-1:0] A_MVAL  = 3'd2;
    localparam logic [ADDR_W-1:0] A_NINV  = 3'd3;
    localparam logic [ADDR_W-1:0] A_DINV  = 3'd4;

    localparam logic [MODE_W-1:0] MODE_FRAC = 2'd2;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
        logic             frac_on;
        logic [MND_W-1:0] m;
        logic [MND_W:0]   n;
        logic [MND_W-1:0] h;
    } act_cfg_t;
endpackage

// File: rtl/mnd_rcg_regs.sv
// Register file: holds the software shadow registers and the pending-commit
// bit, and loads the decoded active configuration when apply is asserted.
// Assumes a single-cycle write strobe and combinational reads.
module mnd_rcg_regs
    import mnd_rcg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              apply,
    output logic              pending,
    output act_cfg_t          act
);
    logic [DIV_W-1:0]  sh_div;
    logic [SRC_W-1:0]  sh_src;
    logic [MODE_W-1:0] sh_mode;
    logic [MND_W-1:0]  sh_m;
    logic [MND_W-1:0]  sh_ninv;
    logic [MND_W-1:0]  sh_dinv;
    logic              pend_q;
    act_cfg_t          act_q;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    // Shadow register writes, masked to their field widths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_div  <= '0;
            sh_src  <= '0;
            sh_mode <= '0;
            sh_m    <= '0;
            sh_ninv <= '0;
            sh_dinv <= '0;
        end else if (wr) begin
            case (addr)
                A_SETUP: begin
                    sh_div  <= wdata[DIV_LSB  +: DIV_W];
                    sh_src  <= wdata[SRC_LSB  +: SRC_W];
                    sh_mode <= wdata[MODE_LSB +: MODE_W];
                end
                A_MVAL:  sh_m    <= wdata[MND_W-1:0];
                A_NINV:  sh_ninv <= wdata[MND_W-1:0];
                A_DINV:  sh_dinv <= wdata[MND_W-1:0];
                default: ;
            endcase
        end
    end

    // Pending-commit bit: a new request wins over the clear from an apply.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (wr && addr == A_CMD && wdata[UPD_BIT])
            pend_q <= 1'b1;
        else if (apply)
            pend_q <= 1'b0;
    end

    // Active configuration: decode the inverted encodings on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (apply) begin
            act_q.src     <= sh_src;
            act_q.div     <= sh_div;
            act_q.frac_on <= (sh_mode == MODE_FRAC) && (sh_m != '0);
            act_q.m       <= sh_m;
            act_q.n       <= {1'b0, ~sh_ninv} + {1'b0, sh_m};
            act_q.h       <= ~sh_dinv;
        end
    end

    // Read mux over the shadow registers and the pending bit.
    always_comb begin
        rdata = '0;
        case (addr)
            A_SETUP: begin
                rdata[DIV_LSB  +: DIV_W]  = sh_div;
                rdata[SRC_LSB  +: SRC_W]  = sh_src;
                rdata[MODE_LSB +: MODE_W] = sh_mode;
            end
            A_CMD:  rdata[UPD_BIT]    = pend_q;
            A_MVAL: rdata[MND_W-1:0]  = sh_m;
            A_NINV: rdata[MND_W-1:0]  = sh_ninv;
            A_DINV: rdata[MND_W-1:0]  = sh_dinv;
            default: ;
        endcase
    end

    assign pending = pend_q;
    assign act     = act_q;
endmodule

// File: rtl/mnd_rcg_src_sel.sv
// Source selector: a behavioural stand-in for the glitch-free clock mux.
// Passes through only the tick of the selected source. A selection beyond
// NUM_SRC yields no ticks.
module mnd_rcg_src_sel
    import mnd_rcg_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic [SRC_W-1:0]   sel,
    output logic               sel_tick
);
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
        // Per-source qualifier: the tick counts only when this source is selected.
        assign hit[i] = src_tick[i] && (sel == SRC_W'(i));
    end

    assign sel_tick = |hit;
endmodule

// File: rtl/mnd_rcg_divider.sv
// Divider core: the integer pre-divider, the M/N accumulator and the
// high-time comparator. Reports the tick that ends the current output
// period. Assumes M < N whenever fractional mode is on.
module mnd_rcg_divider
    import mnd_rcg_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sel_tick,
    input  act_cfg_t       cfg,
    input  logic           apply,
    output logic           period_end,
    output logic [MND_W:0] acc,
    output logic           gen_tick,
    output logic           gen_level
);
    localparam int SUM_W = MND_W + 2;

    logic [DIV_W-1:0] pcnt_q;
    logic [MND_W:0]   acc_q;
    logic             last_pd;
    logic [SUM_W-1:0] acc_sum;
    logic             wrap;
    logic [MND_W:0]   acc_nxt;
    logic             int_high;
    logic             frac_high;
    logic             tick_q;
    logic             level_q;

    // Combinational period position, accumulator step and comparators.
    always_comb begin
        last_pd   = (pcnt_q == cfg.div);
        acc_sum   = {1'b0, acc_q} + {2'b0, cfg.m};
        wrap      = (acc_sum >= {1'b0, cfg.n});
        acc_nxt   = wrap ? (MND_W+1)'(acc_sum - {1'b0, cfg.n}) : acc_sum[MND_W:0];
        int_high  = ({pcnt_q, 1'b0} < ({1'b0, cfg.div} + 1'b1));
        frac_high = ({acc_q, 1'b0} < {2'b0, cfg.h});
    end

    assign period_end = sel_tick && last_pd && (!cfg.frac_on || wrap);

    // Sequential core: advance the counters on selected ticks and restart on apply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q  <= '0;
            acc_q   <= '0;
            tick_q  <= 1'b0;
            level_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (sel_tick) begin
                if (!cfg.frac_on) begin
                    tick_q  <= (pcnt_q == '0);
                    level_q <= int_high;
                end else if (last_pd) begin
                    tick_q  <= ({1'b0, acc_q} < {2'b0, cfg.m});
                    level_q <= frac_high;
                    acc_q   <= acc_nxt;
                end
                pcnt_q <= last_pd ? '0 : pcnt_q + 1'b1;
            end
            if (apply) begin
                pcnt_q <= '0;
                acc_q  <= '0;
            end
        end
    end

    assign acc       = acc_q;
    assign gen_tick  = tick_q;
    assign gen_level = level_q;
endmodule

// File: rtl/mnd_root_clkgen.sv
// Top: fractional root clock generator. It joins the register file, the
// source selector and the divider core. A pending commit is applied on the
// tick that ends the current output period.
module mnd_root_clkgen
    import mnd_rcg_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic               gen_tick,
    output logic               gen_level
);
    act_cfg_t       act_cfg;
    logic           pending;
    logic           period_end;
    logic           apply;
    logic           sel_tick;
    logic [MND_W:0] mn_acc;

    assign apply = pending && period_end;

    mnd_rcg_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .apply   (apply),
        .pending (pending),
        .act     (act_cfg)
    );

    mnd_rcg_src_sel #(.NUM_SRC(NUM_SRC)) u_sel (
        .src_tick (src_tick),
        .sel      (act_cfg.src),
        .sel_tick (sel_tick)
    );

    mnd_rcg_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_tick   (sel_tick),
        .cfg        (act_cfg),
        .apply      (apply),
        .period_end (period_end),
        .acc        (mn_acc),
        .gen_tick   (gen_tick),
        .gen_level  (gen_level)
    );
endmodule

// File: rtl/mnd_root_clkgen_chk.sv
// Checker: temporal properties of the root clock generator, bound to the top.
// Assumes software never programs an N-M difference of zero.
module mnd_root_clkgen_chk
    import mnd_rcg_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               sel_tick,
    input logic               gen_tick,
    input logic               gen_level,
    input logic               pending,
    input logic               period_end,
    input logic               apply,
    input act_cfg_t           act_cfg,
    input logic [MND_W:0]     mn_acc
);
    assert_tick_needs_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_tick && $past(rst_n)) |-> $past(|src_tick));

    assert_level_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sel_tick)) |-> $stable(gen_level));

    assert_pending_clears_on_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(pending)) |-> $past(period_end));

    assert_active_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(apply)) |-> $stable(act_cfg));

    assert_acc_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_cfg.frac_on |-> (mn_acc < act_cfg.n));

    assert_int_acc_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.frac_on |-> (mn_acc == '0));
endmodule

bind mnd_root_clkgen mnd_root_clkgen_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_tick   (src_tick),
    .sel_tick   (sel_tick),
    .gen_tick   (gen_tick),
    .gen_level  (gen_level),
    .pending    (pending),
    .period_end (period_end),
    .apply      (apply),
    .act_cfg    (act_cfg),
    .mn_acc     (mn_acc)
);

// File: tb/mnd_root_clkgen_test.sv
`timescale 1ns/1ps
module mnd_root_clkgen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_tick = '0;
    logic        gen_tick;
    logic        gen_level;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state derived from the requirements.
    int s_div, s_src, s_mode, s_m, s_ninv, s_dinv, s_pend;
    int a_src, a_div, a_frac, a_m, a_n, a_h;
    int pc, acc, e_tick, e_level;

    always #4 clk = ~clk;

    mnd_root_clkgen #(.NUM_SRC(4)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_tick(src_tick),
        .gen_tick(gen_tick), .gen_level(gen_level)
    );

    function automatic int exp_read(int a);
        case (a)
            0: return (s_mode << 12) | (s_src << 8) | s_div;
            1: return s_pend;
            2: return s_m;
            3: return s_ninv;
            4: return s_dinv;
            default: return 0;
        endcase
    endfunction

    task automatic model_reset();
        s_div = 0; s_src = 0; s_mode = 0; s_m = 0; s_ninv = 0; s_dinv = 0; s_pend = 0;
        a_src = 0; a_div = 0; a_frac = 0; a_m = 0; a_n = 0; a_h = 0;
        pc = 0; acc = 0; e_tick = 0; e_level = 0;
    endtask

    task automatic model_step(int tv, int wr, int a, int wd);
        int st, last, wrap, pend_end, app;
        st = (tv >> a_src) & 1;
        last = (pc == a_div);
        wrap = (acc + a_m) >= a_n;
        pend_end = st && last && (!a_frac || wrap);
        app = s_pend && pend_end;
        e_tick = 0;
        if (st) begin
            if (!a_frac) begin
                e_tick = (pc == 0);
                e_level = (2 * pc < a_div + 1);
            end else if (last) begin
                e_tick = (acc < a_m);
                e_level = (2 * acc < a_h);
                acc = wrap ? acc + a_m - a_n : acc + a_m;
            end
            pc = last ? 0 : pc + 1;
        end
        if (app) begin
            pc = 0; acc = 0;
            a_src = s_src; a_div = s_div; a_m = s_m;
            a_frac = (s_mode == 2) && (s_m != 0);
            a_n = ((~s_ninv) & 255) + s_m;
            a_h = (~s_dinv) & 255;
        end
        if (wr && a == 1 && (wd & 1)) s_pend = 1;
        else if (app) s_pend = 0;
        if (wr) begin
            case (a)
                0: begin s_div = wd & 15; s_src = (wd >> 8) & 3; s_mode = (wd >> 12) & 3; end
                2: s_m = wd & 255;
                3: s_ninv = wd & 255;
                4: s_dinv = wd & 255;
                default: ;
            endcase
        end
    endtask

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare at the next falling edge.
    task automatic step(int tv, int wr, int a, int wd, string req);
        src_tick = 4'(tv); bus_wr = 1'(wr); bus_addr = 3'(a); bus_wdata = 32'(wd);
        model_step(tv, wr, a, wd);
        @(posedge clk);
        @(negedge clk);
        chk(req, "gen_tick", int'(gen_tick), e_tick);
        chk(req, "gen_level", int'(gen_level), e_level);
        src_tick = '0; bus_wr = 1'b0;
    endtask

    task automatic rd(int a, int exp, string req);
        bus_addr = 3'(a); bus_wr = 1'b0; src_tick = '0;
        #1;
        chk(req, "rdata", int'(bus_rdata), exp);
        step(0, 0, a, 0, req);
    endtask

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports
        chk("R1", "gen_tick", int'(gen_tick), 0);
        chk("R1", "gen_level", int'(gen_level), 0);
        rd(0, 0, "R1");
        rd(1, 0, "R1");
        rd(4, 0, "R1");
        step(1, 0, 0, 0, "R1");
        chk("R1", "bypass level", int'(gen_level), 1);
        chk("R1", "bypass tick", int'(gen_tick), 1);

        // R2 / R3: program divide-by-2 without committing
        step(0, 1, 0, 32'hFFFF_C0F1, "R3");
        rd(0, 1, "R2");
        step(1, 0, 0, 0, "R3");
        chk("R3", "still bypass", int'(gen_level), 1);
        step(1, 0, 0, 0, "R3");
        chk("R3", "still bypass", int'(gen_level), 1);

        // R4: commit handshake
        step(0, 1, 1, 1, "R4");
        rd(1, 1, "R4");
        step(1, 0, 0, 0, "R4");
        rd(1, 0, "R4");

        // R5: divide-by-2 waveform
        step(1, 0, 0, 0, "R5");
        chk("R5", "p0 tick", int'(gen_tick), 1);
        chk("R5", "p0 level", int'(gen_level), 1);
        step(1, 0, 0, 0, "R5");
        chk("R5", "p1 level", int'(gen_level), 0);
        step(0, 0, 0, 0, "R10");
        chk("R10", "hold level", int'(gen_level), 0);

        // R2: M masked to 8 bits; unmapped word reads 0
        step(0, 1, 2, 32'h1FF, "R2");
        rd(2, 255, "R2");
        rd(6, 0, "R2");

        // R6 / R7: M=1, N=4, H=4 fractional mode
        step(0, 1, 2, 1, "R7");
        step(0, 1, 3, 32'hFC, "R7");
        step(0, 1, 4, 32'hFB, "R7");
        step(0, 1, 0, 32'h2000, "R6");
        step(0, 1, 1, 1, "R6");
        for (int i = 0; i < 14; i++) step(1, 0, 0, 0, "R6");
        // M=3, N=8, H=6 (inv N-M=5 -> 0xFA, inv H -> 0xF9)
        step(0, 1, 2, 3, "R7");
        step(0, 1, 3, 32'hFA, "R7");
        step(0, 1, 4, 32'hF9, "R7");
        step(0, 1, 1, 1, "R7");
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, "R7");

        // R8: mode 0 with M=3 uses integer path
        step(0, 1, 0, 32'h0003, "R8");
        step(0, 1, 1, 1, "R8");
        for (int i = 0; i < 12; i++) step(1, 0, 0, 0, "R8");
        // R8: mode 2 with M=0 uses integer path
        step(0, 1, 2, 0, "R8");
        step(0, 1, 0, 32'h2001, "R8");
        step(0, 1, 1, 1, "R8");
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R8");

        // R9: switch to source 2, divide-by-3
        step(0, 1, 0, 32'h0202, "R9");
        step(0, 1, 1, 1, "R9");
        for (int i = 0; i < 6; i++) step(4'b0101, 0, 0, 0, "R9");
        for (int i = 0; i < 4; i++) step(4'b0001, 0, 0, 0, "R9");
        for (int i = 0; i < 6; i++) step(4'b0100, 0, 0, 0, "R9");
        rd(1, 0, "R4");

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            int r, tv, wr, a, wd;
            r = int'($urandom % 100);
            tv = int'($urandom % 16);
            wr = 1; a = 0; wd = 0;
            if (r < 4) begin
                a = 0;
                wd = ((($urandom % 2) != 0 ? 2 : 0) << 12) | int'(($urandom % 4) << 8) | int'($urandom % 4);
            end else if (r < 6) begin
                a = 2; wd = int'($urandom % 6);
            end else if (r < 8) begin
                a = 3; wd = (~(1 + int'($urandom % 8))) & 255;
            end else if (r < 10) begin
                a = 4; wd = (~int'($urandom % 24)) & 255;
            end else if (r < 12) begin
                a = 1; wd = 1;
            end else begin
                wr = 0;
            end
            if (r == 50) rd(1, s_pend, "R4");
            else step(tv, wr, a, wd, (a_frac != 0) ? "R6" : "R5");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule